// File: doc/BRIEF.md
# Parallel NOR Flash Unlock Command Decoder

This block is the command front end of a word-wide parallel NOR flash, written as a clocked model. It samples the asynchronous bus controls (chip select, output enable, write strobe) together with the address and data buses. From them it builds qualified write cycles and read cycles. Each write is matched against the multi-step unlock sequences the flash understands.

Every command starts with the same two unlock writes. The third write either finishes the command or selects a branch: a program branch that takes one more write, or an erase branch that needs three more writes and is resolved by its last data byte. When a sequence completes, the block emits a one-cycle command pulse with a command code, the target address and the data word. It also tracks whether the device sits in product-ID mode. An interleaved read, a wrong step, a busy internal operation or a reset throws away any partial sequence.

The array, the operation timers and high-voltage pin detection sit outside this block. They consume the command pulse and return a busy indication.

Top module: `nor_unlock_decoder`

## Requirements
- R1: After reset, `cmd_valid` is 0 and `id_mode` is 0.
- R2: A write counts only when, on the bus, chip select is low and output enable is high at the falling edge of the write strobe and still at its rising edge. Any other write-strobe pulse is ignored and leaves a partial sequence exactly where it was.
- R3: Unlock addresses are matched on address bits 14..0 only, and command bytes on data bits 7..0 only. Address bits above 14 and data bits 15..8 never affect matching.
- R4: The writes AA@5555, 55@2AAA, A0@5555 followed by any fourth write produce a pulse with `cmd_kind`=1 (program), carrying the address and full data word of the fourth write.
- R5: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 produce `cmd_kind`=2 (chip erase). A final byte of 10 at any other address produces nothing.
- R6: After the same five-write erase prefix, a sixth write of 30 at any address produces `cmd_kind`=3 (block erase) and a sixth write of 50 at any address produces `cmd_kind`=4 (page erase). Either one reports that sixth address.
- R7: After the erase prefix, 40@5555 produces `cmd_kind`=5 (boot-block lockout enable). Any sixth byte other than 10, 30, 40 or 50 produces nothing.
- R8: The writes AA@5555, 55@2AAA, 90@5555 produce `cmd_kind`=6 (ID entry) and set `id_mode` to 1. Any other third byte, except A0 and 80, produces nothing.
- R9: While `id_mode` is 1, either a single write of F0 at any address or the writes AA@5555, 55@2AAA, F0@5555 produces `cmd_kind`=7 (ID exit) and clears `id_mode`. While `id_mode` is 0, F0 produces nothing.
- R10: A read cycle (chip select and output enable both low) or a write that does not match the expected step aborts the sequence. The next command must start again from its first write.
- R11: The reported address is the one present at the falling edge of the write strobe. The reported data is the word present at its rising edge.
- R12: While `busy` is high, writes are ignored, no command is issued, and any partial sequence is cleared.
- R13: Every completed sequence gives exactly one `cmd_valid` pulse, one clock cycle long, and `cmd_kind` is never 0 during the pulse.
- R14: Driving `rst_n` low at any time, without a clock edge, returns the decoder to idle and clears `id_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_addr | input | ADDR_W (18) | Word address |
| bus_data | input | DATA_W (16) | Write data word |
| busy | input | 1 | Internal program or erase in progress |
| cmd_valid | output | 1 | One-cycle pulse for a recognised command |
| cmd_kind | output | 3 | Command code (1 program … 7 ID exit) |
| cmd_addr | output | ADDR_W (18) | Target address of the command |
| cmd_data | output | DATA_W (16) | Data word of the final write |
| id_mode | output | 1 | Product-ID mode is active |

## Verification
The bench sweeps all 256 values of the third-step byte and all 256 values of the sixth-step byte. The expected command is computed from the byte. This exposes a decoder that lets a near-miss code through, or that compares the don't-care high data byte. The unlock addresses are driven with upper address bits set, and the sixth write uses an address that changes during the strobe and data that changes at the rising edge. A design that matched too many address bits, or sampled the latched fields at the wrong strobe edge, would report the wrong target or drop the command. Further cases cover a read, a mismatched step, a busy period, a strobe cancelled by chip select and an asynchronous reset, each placed inside a partial sequence. A decoder that resumes after an abort fires a spurious program. One that honours an inhibited strobe loses the sequence that follows it.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NONE        = 3'd0,
    CMD_PROGRAM     = 3'd1,
    CMD_CHIP_ERASE  = 3'd2,
    CMD_BLOCK_ERASE = 3'd3,
    CMD_PAGE_ERASE  = 3'd4,
    CMD_BOOT_LOCK   = 3'd5,
    CMD_ID_ENTER    = 3'd6,
    CMD_ID_LEAVE    = 3'd7
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_U1   = 3'd1,
    ST_U2   = 3'd2,
    ST_PGM  = 3'd3,
    ST_E3   = 3'd4,
    ST_E4   = 3'd5,
    ST_E5   = 3'd6
  } step_e;

  localparam logic [31:0] UNLOCK_ADDR_A = 32'h0000_5555;
  localparam logic [31:0] UNLOCK_ADDR_B = 32'h0000_2AAA;

  localparam int unsigned K_UNLOCK_A = 0;
  localparam int unsigned K_UNLOCK_B = 1;
  localparam int unsigned K_PROGRAM  = 2;
  localparam int unsigned K_ERASE    = 3;
  localparam int unsigned K_ID_ENTER = 4;
  localparam int unsigned K_ID_LEAVE = 5;
  localparam int unsigned K_CHIP     = 6;
  localparam int unsigned K_BLOCK    = 7;
  localparam int unsigned K_PAGE     = 8;
  localparam int unsigned K_LOCK     = 9;
  localparam int unsigned NKEYS      = 10;

  function automatic logic [7:0] key_code(input int unsigned idx);
    logic [7:0] v;
    case (idx)
      K_UNLOCK_A: v = 8'hAA;
      K_UNLOCK_B: v = 8'h55;
      K_PROGRAM:  v = 8'hA0;
      K_ERASE:    v = 8'h80;
      K_ID_ENTER: v = 8'h90;
      K_ID_LEAVE: v = 8'hF0;
      K_CHIP:     v = 8'h10;
      K_BLOCK:    v = 8'h30;
      K_PAGE:     v = 8'h50;
      K_LOCK:     v = 8'h40;
      default:    v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/nor_bus_sampler.sv
module nor_bus_sampler #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_stb
);

  logic              s_ce_n, s_oe_n, s_we_n, we_q;
  logic [ADDR_W-1:0] s_addr, open_addr;
  logic [DATA_W-1:0] s_data;
  logic              wr_open, wr_open_nxt;
  logic              qual, fall, rise;
  logic              open_addr_en, wr_stb_nxt, rd_stb_nxt;

  // input capture stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ce_n <= 1'b1;
      s_oe_n <= 1'b1;
      s_we_n <= 1'b1;
      we_q   <= 1'b1;
      s_addr <= '0;
      s_data <= '0;
    end else begin
      s_ce_n <= ce_n;
      s_oe_n <= oe_n;
      s_we_n <= we_n;
      we_q   <= s_we_n;
      s_addr <= addr;
      s_data <= data;
    end
  end

  always_comb begin
    qual         = !s_ce_n && s_oe_n;
    fall         = we_q && !s_we_n;
    rise         = !we_q && s_we_n;
    open_addr_en = fall && qual;
    wr_open_nxt  = wr_open;
    if (open_addr_en)
      wr_open_nxt = 1'b1;
    else if (rise || !qual)
      wr_open_nxt = 1'b0;
    wr_stb_nxt   = rise && wr_open && qual;
    rd_stb_nxt   = !s_ce_n && !s_oe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_open   <= 1'b0;
      open_addr <= '0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      rd_stb    <= 1'b0;
    end else begin
      wr_open <= wr_open_nxt;
      wr_stb  <= wr_stb_nxt;
      rd_stb  <= rd_stb_nxt;
      if (open_addr_en)
        open_addr <= s_addr;
      if (wr_stb_nxt) begin
        wr_addr <= open_addr;
        wr_data <= s_data;
      end
    end
  end

  AST_WR_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R13
  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb)); // R10

endmodule

// File: rtl/nor_key_match.sv
module nor_key_match
  import nor_cmd_pkg::*;
#(
  parameter int MATCH_W = 15,
  parameter int KEY_W   = 8
) (
  input  logic [MATCH_W-1:0] addr_lo,
  input  logic [KEY_W-1:0]   key,
  output logic               at_a,
  output logic               at_b,
  output logic [NKEYS-1:0]   key_hit
);

  assign at_a = (addr_lo == UNLOCK_ADDR_A[MATCH_W-1:0]);
  assign at_b = (addr_lo == UNLOCK_ADDR_B[MATCH_W-1:0]);

  for (genvar i = 0; i < NKEYS; i++) begin : g_key
    localparam logic [7:0] CODE = key_code(i);
    assign key_hit[i] = (key == CODE[KEY_W-1:0]);
  end

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  input  logic              at_a,
  input  logic              at_b,
  input  logic [NKEYS-1:0]  key_hit,
  output logic              cmd_valid,
  output logic [2:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              id_mode
);

  step_e     step, step_nxt;
  cmd_kind_e kind_q, kind_nxt;
  logic      fire, id_nxt;
  logic      first_ok, second_ok;

  always_comb begin
    first_ok  = at_a && key_hit[K_UNLOCK_A];
    second_ok = at_b && key_hit[K_UNLOCK_B];
    step_nxt  = step;
    id_nxt    = id_mode;
    fire      = 1'b0;
    kind_nxt  = CMD_NONE;
    if (busy) begin
      step_nxt = ST_IDLE;
    end else if (rd_stb) begin
      step_nxt = ST_IDLE;
    end else if (wr_stb) begin
      step_nxt = ST_IDLE;
      case (step)
        ST_IDLE: begin
          if (id_mode && key_hit[K_ID_LEAVE]) begin
            fire     = 1'b1;
            kind_nxt = CMD_ID_LEAVE;
            id_nxt   = 1'b0;
          end else if (first_ok) begin
            step_nxt = ST_U1;
          end
        end
        ST_U1: if (second_ok) step_nxt = ST_U2;
        ST_U2: begin
          if (at_a && key_hit[K_PROGRAM]) begin
            step_nxt = ST_PGM;
          end else if (at_a && key_hit[K_ERASE]) begin
            step_nxt = ST_E3;
          end else if (at_a && key_hit[K_ID_ENTER]) begin
            fire     = 1'b1;
            kind_nxt = CMD_ID_ENTER;
            id_nxt   = 1'b1;
          end else if (at_a && key_hit[K_ID_LEAVE] && id_mode) begin
            fire     = 1'b1;
            kind_nxt = CMD_ID_LEAVE;
            id_nxt   = 1'b0;
          end
        end
        ST_PGM: begin
          fire     = 1'b1;
          kind_nxt = CMD_PROGRAM;
        end
        ST_E3: if (first_ok) step_nxt = ST_E4;
        ST_E4: if (second_ok) step_nxt = ST_E5;
        ST_E5: begin
          if (at_a && key_hit[K_CHIP]) begin
            fire = 1'b1; kind_nxt = CMD_CHIP_ERASE;
          end else if (key_hit[K_BLOCK]) begin
            fire = 1'b1; kind_nxt = CMD_BLOCK_ERASE;
          end else if (key_hit[K_PAGE]) begin
            fire = 1'b1; kind_nxt = CMD_PAGE_ERASE;
          end else if (at_a && key_hit[K_LOCK]) begin
            fire = 1'b1; kind_nxt = CMD_BOOT_LOCK;
          end
        end
        default: step_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step      <= ST_IDLE;
      id_mode   <= 1'b0;
      cmd_valid <= 1'b0;
      kind_q    <= CMD_NONE;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      step      <= step_nxt;
      id_mode   <= id_nxt;
      cmd_valid <= fire;
      if (fire) begin
        kind_q   <= kind_nxt;
        cmd_addr <= wr_addr;
        cmd_data <= wr_data;
      end
    end
  end

  assign cmd_kind = kind_q;

  AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !cmd_valid); // R12
  AST_READ_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (step == ST_IDLE)); // R10
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R13
  AST_CMD_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (kind_q != CMD_NONE)); // R13
  AST_ENTER_SETS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && kind_q == CMD_ID_ENTER) |-> id_mode); // R8
  AST_LEAVE_CLEARS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && kind_q == CMD_ID_LEAVE) |-> !id_mode); // R9

endmodule

// File: rtl/nor_unlock_decoder.sv
module nor_unlock_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int MATCH_W = 15,
  parameter int KEY_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              busy,
  output logic              cmd_valid,
  output logic [2:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              id_mode
);

  logic              rst_q1, rst_q2;
  logic              wr_stb, rd_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              at_a, at_b;
  logic [NKEYS-1:0]  key_hit;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  nor_bus_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sample (
    .clk(clk), .rst_n(rst_q2),
    .ce_n(bus_ce_n), .oe_n(bus_oe_n), .we_n(bus_we_n),
    .addr(bus_addr), .data(bus_data),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .rd_stb(rd_stb)
  );

  nor_key_match #(.MATCH_W(MATCH_W), .KEY_W(KEY_W)) u_match (
    .addr_lo(wr_addr[MATCH_W-1:0]), .key(wr_data[KEY_W-1:0]),
    .at_a(at_a), .at_b(at_b), .key_hit(key_hit)
  );

  nor_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_q2), .busy(busy),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .rd_stb(rd_stb),
    .at_a(at_a), .at_b(at_b), .key_hit(key_hit),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .id_mode(id_mode)
  );

endmodule

// File: tb/sim_nor_unlock_decoder.sv
module sim_nor_unlock_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, oe_n, we_n, busy;
  logic [17:0] addr;
  logic [15:0] data;
  logic        cmd_valid, id_mode;
  logic [2:0]  cmd_kind;
  logic [17:0] cmd_addr;
  logic [15:0] cmd_data;

  int checks = 0;
  int fails  = 0;
  int npulse = 0;
  logic [2:0]  lk;
  logic [17:0] la;
  logic [15:0] ld;
  bit done = 0;

  always #2 clk = ~clk;

  nor_unlock_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_data(data), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .id_mode(id_mode)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      npulse = npulse + 1;
      lk = cmd_kind; la = cmd_addr; ld = cmd_data;
    end
  end

  task automatic wr(input logic [17:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; data = d; ce_n = 0; oe_n = 1; we_n = 0;
    @(negedge clk); @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
  endtask

  // address moves after the falling strobe, data settles at the rising strobe
  task automatic wr_split(input logic [17:0] a0, input logic [17:0] a1,
                          input logic [15:0] d0, input logic [15:0] d1);
    @(negedge clk); addr = a0; data = d0; ce_n = 0; oe_n = 1; we_n = 0;
    @(negedge clk); addr = a1;
    @(negedge clk); data = d1; we_n = 1;
    @(negedge clk); ce_n = 1; addr = 18'h0; data = 16'h0;
  endtask

  task automatic rd(input logic [17:0] a);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
    @(negedge clk); @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic unlock2();
    wr(18'h05555, 16'h00AA);
    wr(18'h02AAA, 16'h0055);
  endtask

  task automatic erase_prefix();
    unlock2();
    wr(18'h05555, 16'h0080);
    unlock2();
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_cmd(input int base, input logic [2:0] k, input logic [17:0] a,
                            input logic [15:0] d, input string tag);
    checks++;
    if (k == 3'd0) begin
      if (npulse != base) begin
        fails++;
        $display("FAIL %s: pulses=%0d expected=%0d", tag, npulse - base, 0);
      end
    end else if (npulse != base + 1 || lk != k || la != a || ld != d) begin
      fails++;
      $display("FAIL %s: pulses=%0d kind=%0d addr=%h data=%h expected pulses=1 kind=%0d addr=%h data=%h",
               tag, npulse - base, lk, la, ld, k, a, d);
    end
  endtask

  task automatic expect_id(input logic e, input string tag);
    checks++;
    if (id_mode !== e) begin
      fails++;
      $display("FAIL %s: id_mode=%b expected=%b", tag, id_mode, e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; busy = 0; addr = '0; data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    checks++;
    if (cmd_valid !== 1'b0) begin fails++; $display("FAIL R1: cmd_valid=%b expected=0", cmd_valid); end
    expect_id(1'b0, "R1");

    // R8 sweep over the third-step byte
    for (int b = 0; b < 256; b++) begin
      base = npulse;
      unlock2();
      wr(18'h05555, {8'h5A, b[7:0]});
      settle();
      if (b[7:0] == 8'h90) begin
        expect_cmd(base, 3'd6, 18'h05555, {8'h5A, 8'h90}, "R8 third-step sweep");
        expect_id(1'b1, "R8");
        base = npulse;
        wr(18'h31234, 16'hEEF0);
        settle();
        expect_cmd(base, 3'd7, 18'h31234, 16'hEEF0, "R9 single-write exit");
        expect_id(1'b0, "R9");
      end else begin
        expect_cmd(base, 3'd0, 18'h0, 16'h0, "R8 third-step sweep");
        rd(18'h00000);
        settle();
      end
    end

    // R5 R6 R7 sweep over the sixth-step byte, address with bits above 14 set (R3)
    for (int b = 0; b < 256; b++) begin
      logic [2:0] k;
      base = npulse;
      erase_prefix();
      wr(18'h25555, {8'hC3, b[7:0]});
      settle();
      case (b[7:0])
        8'h10: k = 3'd2;
        8'h30: k = 3'd3;
        8'h50: k = 3'd4;
        8'h40: k = 3'd5;
        default: k = 3'd0;
      endcase
      expect_cmd(base, k, 18'h25555, {8'hC3, b[7:0]}, "R7 sixth-step sweep");
      rd(18'h0);
      settle();
    end

    // R6 R5 R7: sixth write away from the unlock address
    base = npulse; erase_prefix(); wr(18'h0ABCD, 16'h0030); settle();
    expect_cmd(base, 3'd3, 18'h0ABCD, 16'h0030, "R6 block erase any address");
    base = npulse; erase_prefix(); wr(18'h0ABCD, 16'h0050); settle();
    expect_cmd(base, 3'd4, 18'h0ABCD, 16'h0050, "R6 page erase any address");
    base = npulse; erase_prefix(); wr(18'h0ABCD, 16'h0010); settle();
    expect_cmd(base, 3'd0, 18'h0, 16'h0, "R5 chip erase off address");
    base = npulse; erase_prefix(); wr(18'h0ABCD, 16'h0040); settle();
    expect_cmd(base, 3'd0, 18'h0, 16'h0, "R7 lockout off address");

    // R4 program
    base = npulse; unlock2(); wr(18'h05555, 16'h00A0); wr(18'h3FFFF, 16'h1234); settle();
    expect_cmd(base, 3'd1, 18'h3FFFF, 16'h1234, "R4 program");

    // R3 upper address / data bits ignored during unlock
    base = npulse;
    wr(18'h3D555, 16'hFFAA); wr(18'h2AAAA, 16'h1255); wr(18'h1D555, 16'h77A0);
    wr(18'h00100, 16'hBEEF); settle();
    expect_cmd(base, 3'd1, 18'h00100, 16'hBEEF, "R3 high bits ignored");
    base = npulse;
    wr(18'h05554, 16'h00AA); wr(18'h02AAA, 16'h0055); wr(18'h05555, 16'h00A0);
    wr(18'h00100, 16'h1111); settle();
    expect_cmd(base, 3'd0, 18'h0, 16'h0, "R3 low address bit compared");

    // R11 address at falling strobe, data at rising strobe
    base = npulse; erase_prefix();
    wr_split(18'h12345, 18'h00ABC, 16'h0050, 16'h9930); settle();
    expect_cmd(base, 3'd3, 18'h12345, 16'h9930, "R11 edge latching");

    // R9 three-write exit and F0 outside ID mode
    base = npulse; unlock2(); wr(18'h05555, 16'h0090); settle();
    expect_cmd(base, 3'd6, 18'h05555, 16'h0090, "R8 entry");
    base = npulse; unlock2(); wr(18'h05555, 16'h00F0); settle();
    expect_cmd(base, 3'd7, 18'h05555, 16'h00F0, "R9 three-write exit");
    expect_id(1'b0, "R9");
    base = npulse; wr(18'h00042, 16'h00F0); settle();
    expect_cmd(base, 3'd0, 18'h0, 16'h0, "R9 F0 outside ID mode");

    // R10 read aborts, no resume
    base = npulse; unlock2(); rd(18'h05555); wr(18'h05555, 16'h00A0); wr(18'h00200, 16'h2222); settle();
    expect_cmd(base, 3'd0, 18'h0, 16'h0, "R10 read abort");
    base = npulse; unlock2(); wr(18'h02AAA, 16'h0056); wr(18'h02AAA, 16'h0055);
    wr(18'h05555, 16'h00A0); wr(18'h00200, 16'h2222); settle();
    expect_cmd(base, 3'd0, 18'h0, 16'h0, "R10 mismatch abort");

    // R2 inhibited strobes leave progress intact
    base = npulse; unlock2();
    @(negedge clk); addr = 18'h05555; data = 16'h0011; ce_n = 1; oe_n = 1; we_n = 0;
    @(negedge clk); we_n = 1; @(negedge clk);
    @(negedge clk); addr = 18'h05555; data = 16'h0077; ce_n = 0; oe_n = 1; we_n = 0;
    @(negedge clk); ce_n = 1; @(negedge clk); we_n = 1; @(negedge clk);
    wr(18'h05555, 16'h00A0); wr(18'h00300, 16'h3333); settle();
    expect_cmd(base, 3'd1, 18'h00300, 16'h3333, "R2 inhibited writes ignored");

    // R12 busy
    base = npulse; busy = 1;
    unlock2(); wr(18'h05555, 16'h00A0); wr(18'h00400, 16'h4444); settle();
    busy = 0;
    expect_cmd(base, 3'd0, 18'h0, 16'h0, "R12 busy ignores writes");
    base = npulse; unlock2();
    @(negedge clk); busy = 1; @(negedge clk); busy = 0;
    wr(18'h05555, 16'h00A0); wr(18'h00400, 16'h4444); settle();
    expect_cmd(base, 3'd0, 18'h0, 16'h0, "R12 busy clears progress");

    // R14 asynchronous reset mid-sequence
    base = npulse; unlock2(); wr(18'h05555, 16'h00A0);
    @(negedge clk); #1 rst_n = 0; #1 rst_n = 1;
    repeat (4) @(negedge clk);
    wr(18'h00500, 16'h5555); settle();
    expect_cmd(base, 3'd0, 18'h0, 16'h0, "R14 reset mid-sequence");
    unlock2(); wr(18'h05555, 16'h0090); settle();
    expect_id(1'b1, "R14 before reset");
    @(negedge clk); #1 rst_n = 0;
    #0.5 expect_id(1'b0, "R14 cleared without clock");
    #0.5 rst_n = 1;
    repeat (4) @(negedge clk);

    // R13 still works after reset
    base = npulse; erase_prefix(); wr(18'h05555, 16'h0010); settle();
    expect_cmd(base, 3'd2, 18'h05555, 16'h0010, "R13 single pulse chip erase");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule